// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block turns a decimal digit that arrives one bit per strobe, least significant bit first, into its Excess-3 form (the digit plus three), delivered on a single serial output in the same order. Each output bit is a combinational function of the registered state and the input bit on the wire at that moment. The result bit is therefore available in the same cycle as the input bit that produces it, and no pipeline delay is added.

Internally the block adds the constant three bit by bit. Its state holds the bit position inside the digit and whether a carry is pending from the previous position. Position zero can never hold a pending carry, so with four-bit digits there are only seven reachable states, and they fit in three flip-flops. After the fourth strobed bit, the machine drops any carry and returns to its starting state on its own, so digits can be sent back to back with no framing signal. Codes above nine are not checked. They still consume four strobes, so framing stays aligned.

A chip-level active-low reset clears the state at once and is released through a short synchronizer. A separate synchronous restart input abandons a partly received digit.

Top module: `e3_serial_conv`

## Requirements
- R1: After reset the machine is at the first bit of a digit with no pending carry, so an input bit b gives an output of b XOR 1 before any strobe.
- R2: For a digit d from 0 to 9 sent bit 0 first, the four strobed output bits, read bit 0 first, equal the low four bits of d+3 (0 gives 0011, 9 gives 1100).
- R3: The output responds to the input bit within the same cycle. At the second bit position with a pending carry it equals the input bit, and at the first position it is the inverse of the input bit.
- R4: The state changes only on clock edges where `bit_vld` or `restart` is high. Idle cycles with any `bit_in` value between strobes leave the conversion result unchanged.
- R5: After the fourth strobed bit the machine is back at its starting state, so the next strobe begins a new digit with no idle cycle in between.
- R6: A code from 10 to 15 still consumes exactly four strobes, and whatever carry it leaves is discarded. The digit that follows converts correctly.
- R7: `restart` high at a clock edge returns the machine to its starting state. It takes priority over a simultaneous `bit_vld`.
- R8: `rst_n` low clears a partly received digit at any time. After release, the next digit converts correctly.
- R9: The first bit position never holds a pending carry, so at most seven state codes occur in the three state flip-flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| restart | input | 1 | Synchronous return to the start of a digit |
| bit_vld | input | 1 | Strobe: `bit_in` carries a digit bit this cycle |
| bit_in | input | 1 | Serial digit input, least significant bit first |
| bit_out | output | 1 | Serial Excess-3 output, valid in cycles where `bit_vld` is high |

## Verification
The bench builds the block with its default values: four-bit digits, an offset of three and a two-stage reset synchronizer. These are the only values for which Excess-3 is defined. With them, all sixteen four-bit codes can be driven, so the six unused codes are exercised for framing alongside the ten real digits. The two-stage synchronizer makes the delay between reset release and the first accepted strobe a short, known number of cycles.

// File: rtl/e3_pkg.sv
package e3_pkg;
  // Width of the bit-position counter for a digit of w bits
  function automatic int pos_width(input int w);
    return (w <= 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/e3_rst_sync.sv
module e3_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/e3_bit_adder.sv
module e3_bit_adder (
  input  logic a_bit,
  input  logic k_bit,
  input  logic c_in,
  output logic s_bit,
  output logic c_out
);
  always_comb begin
    s_bit = a_bit ^ k_bit ^ c_in;
    c_out = (a_bit & k_bit) | (a_bit & c_in) | (k_bit & c_in);
  end
endmodule

// File: rtl/e3_step_ctrl.sv
module e3_step_ctrl #(
  parameter int DIGIT_W = 4,
  parameter int POS_W   = 2
) (
  input  logic             restart,
  input  logic             bit_vld,
  input  logic [POS_W-1:0] pos_q,
  input  logic             c_out,
  output logic             st_en,
  output logic [POS_W-1:0] pos_d,
  output logic             carry_d
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(DIGIT_W - 1);

  always_comb begin
    st_en   = restart | bit_vld;
    pos_d   = pos_q;
    carry_d = 1'b0;
    if (restart) begin
      pos_d   = '0;
      carry_d = 1'b0;
    end else if (bit_vld) begin
      if (pos_q == LAST_POS) begin
        pos_d   = '0;
        carry_d = 1'b0;
      end else begin
        pos_d   = pos_q + 1'b1;
        carry_d = c_out;
      end
    end
  end
endmodule

// File: rtl/e3_state_reg.sv
module e3_state_reg #(
  parameter int POS_W = 2
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic             st_en,
  input  logic [POS_W-1:0] pos_d,
  input  logic             carry_d,
  output logic [POS_W-1:0] pos_q,
  output logic             carry_q
);
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pos_q   <= '0;
      carry_q <= 1'b0;
    end else if (st_en) begin
      pos_q   <= pos_d;
      carry_q <= carry_d;
    end
  end
endmodule

// File: rtl/e3_serial_conv.sv
module e3_serial_conv #(
  parameter int                 DIGIT_W     = 4,
  parameter logic [DIGIT_W-1:0] OFFSET      = DIGIT_W'(3),
  parameter int                 SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic bit_vld,
  input  logic bit_in,
  output logic bit_out
);
  localparam int POS_W = e3_pkg::pos_width(DIGIT_W);

  logic             rst_sync_n;
  logic [POS_W-1:0] pos_q;
  logic             carry_q;
  logic [POS_W-1:0] pos_d;
  logic             carry_d;
  logic             st_en;
  logic             k_bit;
  logic             c_out;

  e3_rst_sync #(.STAGES(SYNC_STAGES)) rsync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign k_bit = OFFSET[pos_q];

  e3_bit_adder add_i (
    .a_bit (bit_in),
    .k_bit (k_bit),
    .c_in  (carry_q),
    .s_bit (bit_out),
    .c_out (c_out)
  );

  e3_step_ctrl #(.DIGIT_W(DIGIT_W), .POS_W(POS_W)) ctrl_i (
    .restart (restart),
    .bit_vld (bit_vld),
    .pos_q   (pos_q),
    .c_out   (c_out),
    .st_en   (st_en),
    .pos_d   (pos_d),
    .carry_d (carry_d)
  );

  e3_state_reg #(.POS_W(POS_W)) sreg_i (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .st_en      (st_en),
    .pos_d      (pos_d),
    .carry_d    (carry_d),
    .pos_q      (pos_q),
    .carry_q    (carry_q)
  );
endmodule

// File: rtl/e3_serial_conv_chk.sv
module e3_serial_conv_chk #(
  parameter int                 DIGIT_W = 4,
  parameter logic [DIGIT_W-1:0] OFFSET  = DIGIT_W'(3),
  parameter int                 POS_W   = 2
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             restart,
  input logic             bit_vld,
  input logic             bit_in,
  input logic             bit_out,
  input logic [POS_W-1:0] pos_q,
  input logic             carry_q
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(DIGIT_W - 1);

  // R5: the last strobed bit brings the machine back to its start
  a_r5_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bit_vld && !restart && pos_q == LAST_POS) |=> (pos_q == '0 && !carry_q));

  // R4: no strobe and no restart means the state holds
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bit_vld && !restart) |=> ($stable(pos_q) && $stable(carry_q)));

  // R4: a strobe before the last bit moves one position on
  a_r4_step_on_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bit_vld && !restart && pos_q != LAST_POS) |=> (pos_q == POS_W'($past(pos_q) + 1'b1)));

  // R7: restart wins over the strobe
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    restart |=> (pos_q == '0 && !carry_q));

  // R9: the first position never carries a pending carry
  a_r9_start_no_carry: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pos_q == '0) |-> !carry_q);

  // R3: at the first position the output follows the input in the same cycle
  a_r3_mealy_first_bit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pos_q == '0) |-> (bit_out == (bit_in ^ OFFSET[0])));
endmodule

bind e3_serial_conv e3_serial_conv_chk #(
  .DIGIT_W (DIGIT_W),
  .OFFSET  (OFFSET),
  .POS_W   (POS_W)
) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .restart    (restart),
  .bit_vld    (bit_vld),
  .bit_in     (bit_in),
  .bit_out    (bit_out),
  .pos_q      (pos_q),
  .carry_q    (carry_q)
);

// File: tb/e3_serial_conv_tb.sv
module e3_serial_conv_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk;
  logic rst_n;
  logic restart;
  logic bit_vld;
  logic bit_in;
  logic bit_out;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  e3_serial_conv dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .bit_out (bit_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // stimulus table: {care flag, digit}; codes above nine are framing-only
  localparam logic [4:0] VEC [0:16] = '{
    5'h10, 5'h11, 5'h12, 5'h13, 5'h14, 5'h15, 5'h16, 5'h17, 5'h18, 5'h19,
    5'h0A, 5'h15, 5'h0B, 5'h0C, 5'h0D, 5'h0E, 5'h0F
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] excess3(input logic [3:0] d);
    return 4'(d + 4'd3);
  endfunction

  // drives four strobed bits (gap idle cycles after each), returns the output bits
  task automatic send_digit(input logic [3:0] d, input int gap, output logic [3:0] res);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      bit_vld = 1'b1;
      bit_in  = d[i];
      #1 res[i] = bit_out;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in  = ~d[i];
      end
    end
    @(negedge clk);
    bit_vld = 1'b0;
    bit_in  = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] r;
    rst_n = 1'b0; restart = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
    do_reset();

    // R1 and R3: start state, output follows input without a clock edge
    bit_in = 1'b0; #1 check("R1", {3'b0, bit_out}, 4'd1);
    bit_in = 1'b1; #1 check("R1 R3", {3'b0, bit_out}, 4'd0);
    bit_in = 1'b0;

    // table walk, back to back: R2 on digits, R5 on framing, R6 after don't-cares
    for (int v = 0; v < 17; v++) begin
      send_digit(VEC[v][3:0], 0, r);
      if (VEC[v][4])
        check((v == 11) ? "R2 R6 R9" : "R2 R5", r, excess3(VEC[v][3:0]));
    end
    send_digit(4'd0, 0, r);
    check("R6 R9 after code 15", r, 4'd3);

    // R3: second position with pending carry -> output equals input
    @(negedge clk); bit_vld = 1'b1; bit_in = 1'b1;
    @(negedge clk); bit_vld = 1'b0;
    bit_in = 1'b0; #1 check("R3 pos1 in0", {3'b0, bit_out}, 4'd0);
    bit_in = 1'b1; #1 check("R3 pos1 in1", {3'b0, bit_out}, 4'd1);
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;

    // R4: idle cycles with toggling input between strobes
    send_digit(4'd7, 3, r);
    check("R4 gapped 7", r, 4'd10);
    send_digit(4'd9, 1, r);
    check("R4 gapped 9", r, 4'd12);

    // R7: restart mid-digit with a simultaneous strobe
    @(negedge clk); bit_vld = 1'b1; bit_in = 1'b1;
    @(negedge clk); bit_in = 1'b0;
    @(negedge clk); restart = 1'b1; bit_in = 1'b1;
    @(negedge clk); restart = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
    send_digit(4'd2, 0, r);
    check("R7 restart over strobe", r, 4'd5);

    // R8: asynchronous reset partway through a digit
    @(negedge clk); bit_vld = 1'b1; bit_in = 1'b1;
    @(negedge clk); bit_vld = 1'b0;
    #2 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send_digit(4'd4, 0, r);
    check("R8 reset mid-digit", r, 4'd7);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule